// File: doc/BRIEF.md
# Fixed-Latency Strip Hit Compactor

The compactor receives, once per bunch crossing, a vector of hit flags from the channels of one segment of a segmented strip sensor. It packs the addresses of the channels that fired onto a small fixed set of output lanes. Each lane carries an address and a valid bit. Every hit reaches the lanes after the same number of clock cycles, however many hits the crossing holds and wherever they sit. The downstream readout can therefore tie each lane word to its crossing by counting cycles alone.

For every channel, a short chain of saturating incrementers works out how many lower-numbered channels fired in the same crossing. That rank is the lane index the channel's address is steered to. The channel row is split into a lower group, one middle channel and an upper group. The two groups are ranked in parallel, and a second pipeline stage adds the lower group's total to the upper ranks.

A channel whose rank is at or beyond the lane count is dropped, and no queue is kept. An overflow flag marks the crossing in which this happened. An optional build variant attaches a row code, sampled with the crossing, to every occupied lane.

Top module: `strip_hit_compactor`

## Requirements
- R1: Synchronous active-high `rst` clears the pipeline. On the first falling clock edge after a rising edge with `rst` high, `lane_valid` is 0, `overflow` is 0, and every `lane_addr` and `lane_row` field is 0.
- R2: A crossing presented on `hit_in` before rising edge E appears on the outputs after rising edge E+2, which is three edges. This latency is the same for every hit pattern.
- R3: Lane k occupies bits `lane_addr[k*ADDR_W +: ADDR_W]`. It carries the binary channel index of the (k+1)-th lowest-numbered hit channel of its crossing. Valid lanes therefore hold strictly increasing addresses.
- R4: Exactly min(H, LANES) lanes are valid, where H is the number of hits in the crossing. The valid lanes always form the contiguous group starting at lane 0.
- R5: When H > LANES, the hits above the LANES lowest-numbered ones are discarded and `overflow` is 1 for that crossing. Otherwise `overflow` is 0.
- R6: Crossings presented on consecutive cycles never mix. Each output cycle depends only on the single crossing it belongs to.
- R7: With ROW_EN set, every valid lane carries in `lane_row[k*ROW_W +: ROW_W]` the `row_in` value sampled with its crossing. Invalid lanes show row 0.
- R8: Every invalid lane shows address 0.
- R9: Ranking is correct across the group boundaries. Hits in the last lower-group channel, the middle channel and the first upper-group channel (14, 15, 16 by default) take consecutive lanes in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | NUM_CHAN | Hit flag per channel, bit i is channel i |
| row_in | input | ROW_W | Row code of the crossing |
| lane_addr | output | LANES*ADDR_W | Channel address per lane |
| lane_row | output | LANES*ROW_W | Row code per lane, zero if ROW_EN is clear |
| lane_valid | output | LANES | Lane occupied |
| overflow | output | 1 | Hits were dropped in this crossing |

## Verification
The hardest case to reach is a long run of back-to-back crossings that alternate between overflowing and sparse patterns. This is where a misaligned pipeline register, or a lower-group total taken from the wrong crossing, would leak hits between crossings. The stimulus streams every single-hit and every two-hit pattern, threshold fills just below and just above the lane count, and boundary patterns around the middle channel. It then runs thousands of pseudo-random vectors of varying density without gaps. Each output cycle is compared with a prediction built from the vector presented three cycles earlier.

// File: rtl/shc_pkg.sv
package shc_pkg;

  localparam int SHC_LANES_DEF  = 8;
  localparam int SHC_ADDR_W_DEF = 8;

  // clamp a running count so counters stay narrow but still show "more than full"
  function automatic int sat_cap(input int value, input int cap);
    return (value > cap) ? cap : value;
  endfunction

endpackage

// File: rtl/shc_group_rank.sv
module shc_group_rank
  import shc_pkg::*;
#(
  parameter int N     = 15,
  parameter int CNT_W = 4,
  parameter int CAP   = 9
) (
  input  logic [N-1:0]       hits,
  output logic [N*CNT_W-1:0] rank_flat,
  output logic [CNT_W-1:0]   total
);

  // ripple of saturating incrementers: each stage adds one when its channel fired
  always_comb begin
    int cnt;
    cnt = 0;
    rank_flat = '0;
    for (int i = 0; i < N; i++) begin
      rank_flat[i*CNT_W +: CNT_W] = CNT_W'(cnt);
      if (hits[i]) cnt = sat_cap(cnt + 1, CAP);
    end
    total = CNT_W'(cnt);
  end

endmodule

// File: rtl/shc_lane_steer.sv
module shc_lane_steer #(
  parameter int NUM_CHAN = 31,
  parameter int LANES    = 8,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 4
) (
  input  logic [NUM_CHAN-1:0]       hits,
  input  logic [NUM_CHAN*CNT_W-1:0] rank_flat,
  output logic [LANES*ADDR_W-1:0]   lane_addr,
  output logic [LANES-1:0]          lane_valid
);

  // one enabled demultiplexer per channel, folded here as an OR per lane;
  // ranks of hit channels are unique, so at most one source per lane
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      logic [ADDR_W-1:0] acc;
      logic              any;
      acc = '0;
      any = 1'b0;
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (hits[c] && (rank_flat[c*CNT_W +: CNT_W] == CNT_W'(j))) begin
          acc = acc | ADDR_W'(c);
          any = 1'b1;
        end
      end
      lane_addr[j*ADDR_W +: ADDR_W] = acc;
      lane_valid[j] = any;
    end
  end

endmodule

// File: rtl/strip_hit_compactor.sv
module strip_hit_compactor
  import shc_pkg::*;
#(
  parameter int NUM_CHAN = 31,
  parameter int LANES    = SHC_LANES_DEF,
  parameter int ADDR_W   = SHC_ADDR_W_DEF,
  parameter int ROW_W    = 3,
  parameter bit ROW_EN   = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CHAN-1:0]       hit_in,
  input  logic [ROW_W-1:0]          row_in,
  output logic [LANES*ADDR_W-1:0]   lane_addr,
  output logic [LANES*ROW_W-1:0]    lane_row,
  output logic [LANES-1:0]          lane_valid,
  output logic                      overflow
);

  localparam int CAP     = LANES + 1;
  localparam int CNT_W   = $clog2(CAP + 1);
  localparam int LO_N    = (NUM_CHAN - 1) / 2;
  localparam int MID     = LO_N;
  localparam int HI_BASE = MID + 1;
  localparam int HI_N    = NUM_CHAN - HI_BASE;

  // ---------------- stage 1: capture crossing ----------------
  logic [NUM_CHAN-1:0] s1_hit;
  logic [ROW_W-1:0]    s1_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_hit <= '0;
      s1_row <= '0;
    end else begin
      s1_hit <= hit_in;
      s1_row <= row_in;
    end
  end

  // ---------------- group ranking (parallel) ----------------
  logic [LO_N*CNT_W-1:0] lo_rank;
  logic [HI_N*CNT_W-1:0] hi_rank;
  logic [CNT_W-1:0]      lo_tot, hi_tot;

  shc_group_rank #(.N(LO_N), .CNT_W(CNT_W), .CAP(CAP)) u_rank_lo (
    .hits      (s1_hit[LO_N-1:0]),
    .rank_flat (lo_rank),
    .total     (lo_tot)
  );

  shc_group_rank #(.N(HI_N), .CNT_W(CNT_W), .CAP(CAP)) u_rank_hi (
    .hits      (s1_hit[NUM_CHAN-1:HI_BASE]),
    .rank_flat (hi_rank),
    .total     (hi_tot)
  );

  // ---------------- stage 2: local ranks registered ----------------
  logic [NUM_CHAN-1:0]   s2_hit;
  logic [ROW_W-1:0]      s2_row;
  logic [LO_N*CNT_W-1:0] s2_lo_rank;
  logic [HI_N*CNT_W-1:0] s2_hi_rank;
  logic [CNT_W-1:0]      s2_lo_tot, s2_hi_tot;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_hit     <= '0;
      s2_row     <= '0;
      s2_lo_rank <= '0;
      s2_hi_rank <= '0;
      s2_lo_tot  <= '0;
      s2_hi_tot  <= '0;
    end else begin
      s2_hit     <= s1_hit;
      s2_row     <= s1_row;
      s2_lo_rank <= lo_rank;
      s2_hi_rank <= hi_rank;
      s2_lo_tot  <= lo_tot;
      s2_hi_tot  <= hi_tot;
    end
  end

  // ---------------- combine: offset upper group by lower total ----------------
  logic [NUM_CHAN*CNT_W-1:0] full_rank;
  logic                      drop_any;

  always_comb begin
    int base;
    int all;
    full_rank = '0;
    for (int i = 0; i < LO_N; i++) begin
      full_rank[i*CNT_W +: CNT_W] = s2_lo_rank[i*CNT_W +: CNT_W];
    end
    full_rank[MID*CNT_W +: CNT_W] = s2_lo_tot;
    base = sat_cap(int'(s2_lo_tot) + int'(s2_hit[MID]), CAP);
    for (int i = 0; i < HI_N; i++) begin
      full_rank[(HI_BASE+i)*CNT_W +: CNT_W] =
        CNT_W'(sat_cap(base + int'(s2_hi_rank[i*CNT_W +: CNT_W]), CAP));
    end
    all = sat_cap(base + int'(s2_hi_tot), CAP);
    drop_any = (all > LANES);
  end

  logic [LANES*ADDR_W-1:0] steer_addr;
  logic [LANES-1:0]        steer_valid;

  shc_lane_steer #(
    .NUM_CHAN (NUM_CHAN),
    .LANES    (LANES),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
  ) u_steer (
    .hits       (s2_hit),
    .rank_flat  (full_rank),
    .lane_addr  (steer_addr),
    .lane_valid (steer_valid)
  );

  // ---------------- row code variant ----------------
  logic [LANES*ROW_W-1:0] row_d;

  if (ROW_EN) begin : g_row
    for (genvar j = 0; j < LANES; j++) begin : g_lane_row
      assign row_d[j*ROW_W +: ROW_W] = steer_valid[j] ? s2_row : '0;
    end
  end else begin : g_no_row
    assign row_d = '0;
  end

  // ---------------- stage 3: registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      lane_addr  <= '0;
      lane_row   <= '0;
      lane_valid <= '0;
      overflow   <= 1'b0;
    end else begin
      lane_addr  <= steer_addr;
      lane_row   <= row_d;
      lane_valid <= steer_valid;
      overflow   <= drop_any;
    end
  end

endmodule

// File: rtl/strip_hit_compactor_chk.sv
module strip_hit_compactor_chk #(
  parameter int NUM_CHAN = 31,
  parameter int LANES    = 8,
  parameter int ADDR_W   = 8,
  parameter int ROW_W    = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CHAN-1:0]     hit_in,
  input logic [LANES*ADDR_W-1:0] lane_addr,
  input logic [LANES*ROW_W-1:0]  lane_row,
  input logic [LANES-1:0]        lane_valid,
  input logic                    overflow
);

  // edges seen since reset, saturating at the pipeline depth
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lane_valid == '0 && !overflow)); // R1

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (rst || since_rst != 2'd3)
    lane_valid[0] == (|$past(hit_in, 3))); // R2

  AST_THERMO_FILL: assert property (@(posedge clk) disable iff (rst)
    (lane_valid & (lane_valid + 1'b1)) == '0); // R4

  AST_OVF_COUNT: assert property (@(posedge clk) disable iff (rst || since_rst != 2'd3)
    overflow == ($countones($past(hit_in, 3)) > LANES)); // R5

  AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (&lane_valid)); // R5

  for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !lane_valid[j] |-> (lane_addr[j*ADDR_W +: ADDR_W] == '0
                          && lane_row[j*ROW_W +: ROW_W] == '0)); // R8
    if (j + 1 < LANES) begin : g_order
      AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        lane_valid[j+1] |-> (lane_addr[(j+1)*ADDR_W +: ADDR_W] > lane_addr[j*ADDR_W +: ADDR_W])); // R3
    end
  end

endmodule

bind strip_hit_compactor strip_hit_compactor_chk #(
  .NUM_CHAN (NUM_CHAN),
  .LANES    (LANES),
  .ADDR_W   (ADDR_W),
  .ROW_W    (ROW_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hit_in     (hit_in),
  .lane_addr  (lane_addr),
  .lane_row   (lane_row),
  .lane_valid (lane_valid),
  .overflow   (overflow)
);

// File: tb/strip_hit_compactor_bench.sv
module strip_hit_compactor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 31;
  localparam int NL    = 8;
  localparam int AW    = 8;
  localparam int RW    = 3;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NCH-1:0]       hit_in = '0;
  logic [RW-1:0]        row_in = '0;
  logic [NL*AW-1:0]     lane_addr;
  logic [NL*RW-1:0]     lane_row;
  logic [NL-1:0]        lane_valid;
  logic                 overflow;

  int checks = 0;
  int failures = 0;

  logic [NCH-1:0] vh [0:2];
  logic [RW-1:0]  rh [0:2];

  always #(CLK_PERIOD/2) clk = ~clk;

  strip_hit_compactor #(
    .NUM_CHAN (NCH), .LANES (NL), .ADDR_W (AW), .ROW_W (RW), .ROW_EN (1'b1)
  ) u_strip_hit_compactor (
    .clk (clk), .rst (rst), .hit_in (hit_in), .row_in (row_in),
    .lane_addr (lane_addr), .lane_row (lane_row),
    .lane_valid (lane_valid), .overflow (overflow)
  );

  // prediction straight from the requirements
  task automatic predict(input logic [NCH-1:0] v, input logic [RW-1:0] r,
                         output logic [NL*AW-1:0] ea, output logic [NL*RW-1:0] er,
                         output logic [NL-1:0] ev, output logic eo);
    int k;
    k = 0; ea = '0; er = '0; ev = '0;
    for (int c = 0; c < NCH; c++) begin
      if (v[c]) begin
        if (k < NL) begin
          ea[k*AW +: AW] = AW'(c);
          er[k*RW +: RW] = r;
          ev[k] = 1'b1;
        end
        k++;
      end
    end
    eo = (k > NL);
  endtask

  task automatic check_outputs(input logic [NCH-1:0] v, input logic [RW-1:0] r);
    logic [NL*AW-1:0] ea; logic [NL*RW-1:0] er; logic [NL-1:0] ev; logic eo;
    predict(v, r, ea, er, ev, eo);
    checks++;
    if (lane_valid !== ev) begin
      failures++;
      $display("FAIL R4 valid act=%b exp=%b hits=%h", lane_valid, ev, v);
    end
    checks++;
    if (overflow !== eo) begin
      failures++;
      $display("FAIL R5 overflow act=%b exp=%b hits=%h", overflow, eo, v);
    end
    checks++;
    if (lane_addr !== ea) begin
      failures++;
      // R2 R3 R6 R8 R9: lane contents of this crossing exactly three edges later
      $display("FAIL R3 addr act=%h exp=%h hits=%h", lane_addr, ea, v);
    end
    checks++;
    if (lane_row !== er) begin
      failures++;
      $display("FAIL R7 row act=%h exp=%h hits=%h", lane_row, er, v);
    end
  endtask

  // one crossing per cycle: check the crossing from three cycles back, then drive
  task automatic step(input logic [NCH-1:0] v, input logic [RW-1:0] r);
    @(negedge clk);
    check_outputs(vh[2], rh[2]);
    vh[2] = vh[1]; rh[2] = rh[1];
    vh[1] = vh[0]; rh[1] = rh[0];
    vh[0] = v;     rh[0] = r;
    hit_in = v; row_in = r;
  endtask

  task automatic check_reset_state();
    checks++;
    if (lane_valid !== '0 || overflow !== 1'b0 || lane_addr !== '0 || lane_row !== '0) begin
      failures++;
      $display("FAIL R1 reset act=v%b o%b a%h r%h exp=zero", lane_valid, overflow, lane_addr, lane_row);
    end
  endtask

  task automatic apply_reset(input logic [NCH-1:0] junk);
    @(negedge clk);
    rst = 1'b1; hit_in = junk; row_in = 3'd5;
    repeat (2) @(negedge clk);
    check_reset_state(); // R1
    rst = 1'b0; hit_in = '0; row_in = '0;
    for (int i = 0; i < 3; i++) begin vh[i] = '0; rh[i] = '0; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lfsr_a;
    logic [31:0] lfsr_b;
    lfsr_a = 32'h1D2C_3B4A;
    lfsr_b = 32'h9E37_79B9;
    for (int i = 0; i < 3; i++) begin vh[i] = '0; rh[i] = '0; end
    repeat (3) @(negedge clk);
    check_reset_state(); // R1
    rst = 1'b0;

    // singles, every channel (R3, R2)
    for (int c = 0; c < NCH; c++) step(NCH'(1) << c, RW'(c));
    // all pairs, back to back (R3, R6)
    for (int a = 0; a < NCH; a++)
      for (int b = a + 1; b < NCH; b++)
        step((NCH'(1) << a) | (NCH'(1) << b), RW'(a + b));
    // prefix and suffix fills across the lane limit (R4, R5)
    for (int k = 0; k <= NCH; k++) step(NCH'((64'd1 << k) - 1), RW'(k));
    for (int k = 0; k <= NCH; k++) step(~(NCH'((64'd1 << (NCH - k)) - 1)), RW'(k));
    // group boundary around the middle channel (R9)
    step(NCH'(7) << 14, 3'd1);
    step(NCH'(1) << 15, 3'd2);
    step(NCH'(32'h0000_7FFF), 3'd3);
    step(NCH'(32'h0001_C07F), 3'd4);
    step(NCH'(32'h0000_807F), 3'd5);
    step(NCH'(32'h0003_803F), 3'd6);
    // alternate overflow and sparse crossings (R6, R5)
    for (int i = 0; i < 16; i++) step((i % 2) ? '1 : NCH'(32'h4000_0001), RW'(i));

    // mid-stream reset (R1)
    apply_reset('1);

    // pseudo-random streams of varying density (R2..R8)
    for (int i = 0; i < 3000; i++) begin
      logic [NCH-1:0] v;
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      case (i % 3)
        0: v = lfsr_a[NCH-1:0];
        1: v = lfsr_a[NCH-1:0] & lfsr_b[NCH-1:0];
        default: v = lfsr_a[NCH-1:0] & lfsr_b[NCH-1:0] & lfsr_a[NCH+0:1];
      endcase
      step(v, lfsr_b[RW-1:0]);
    end
    // drain
    for (int i = 0; i < 4; i++) step('0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule